// File: doc/BRIEF.md
# Stopwatch and Interval Timer

This block keeps time for a processor subsystem with two counters driven by one shared tick. A fixed prescaler divides the system clock by `TICK_DIV` (default 1536) and emits a one-cycle tick. A free-running 12-bit stopwatch counts those ticks. Software clears it by writing to it, and reads it to measure elapsed time.

The second counter is a reloading down-counter. It is programmed with an 8-bit period value. Each time it runs out, it sets a pending flag. The flag drives an interrupt request line through an enable input. The flag stays set until the interrupt controller acknowledges it.

A period value of zero turns the interval timer off. Register access uses a one-bit address, a write strobe and a combinational read port.

Top module: `tick_timer`

## Requirements
- R1: After reset the prescaler starts at phase zero and produces one tick every `TICK_DIV` clock cycles. Successive stopwatch increments are exactly `TICK_DIV` cycles apart.
- R2: The stopwatch (address 0, read as bits [11:0], upper read bits zero) increments by one on every tick and wraps from 0xFFF to 0x000.
- R3: Any write to address 0 clears the stopwatch to zero on the following edge, whatever the write data. A write that lands on a tick edge still leaves zero.
- R4: The period register (address 1) keeps only write data bits [7:0], and reads back zero-extended. Writing it does not move the prescaler phase.
- R5: On a tick with the running count at zero, the count loads the period register. On a tick with a nonzero count, the count decrements.
- R6: The pending flag sets on the tick that takes the count from one to zero, so requests repeat every period+1 ticks. It stays set until `irq_ack` is sampled high. When expiry and acknowledge fall in the same cycle, expiry wins.
- R7: A period value of zero produces no requests. Writing zero also clears a running count, so no request from the old period follows.
- R8: `irq_req` is high only while the pending flag is set and `irq_en` is high. Dropping `irq_en` does not clear the pending flag.
- R9: While reset is applied, the stopwatch reads 0, the period register reads 0 and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 1 | Register select: 0 stopwatch, 1 period |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, zero-extended |
| irq_en | input | 1 | Interrupt enable mask bit |
| irq_ack | input | 1 | Acknowledge that clears the pending flag |
| irq_req | output | 1 | Level interrupt request |

## Verification
Two situations are hard to reach from the ports: an acknowledge that arrives on the very edge where the count expires, and a stopwatch write that coincides with a tick. The internal prescaler phase cannot be read directly. The bench therefore first locks onto it by watching the stopwatch change value. From then on it counts whole tick intervals, so that it can place a strobe on the last cycle before a tick edge. The wrap case needs 4096 ticks, so the bench runs the block with a short divide ratio.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 16;

  typedef enum logic {
    SEL_STOPWATCH = 1'b0,
    SEL_PERIOD    = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 1536
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] phase_q, phase_d;

  always_comb begin
    tick_o  = (phase_q == LAST);
    phase_d = tick_o ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
  AST_TICK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (phase_q == '0)); // R1
endmodule

// File: rtl/tmr_stopwatch.sv
module tmr_stopwatch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q, count_d;
  logic         count_en;

  always_comb begin
    count_en = clr_i | tick_i;
    count_d  = clr_i ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0)); // R3
  AST_SW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i) |=> (count_q == W'($past(count_q) + 1'b1))); // R2
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(count_q)); // R2
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ack_i,
  output logic [W-1:0] period_o,
  output logic         pending_o
);
  logic [W-1:0] period_q, period_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         pend_q, pend_d;
  logic         zero_wr, expire, cnt_en;

  always_comb begin
    zero_wr  = wr_i && (wdata_i == '0);
    period_d = wdata_i;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (zero_wr) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = period_q;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        expire = (cnt_q == W'(1));
      end
    end
    cnt_en = zero_wr | tick_i;
    if (expire)     pend_d = 1'b1;
    else if (ack_i) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_i)   period_q <= period_d;
      if (cnt_en) cnt_q    <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign period_o  = period_q;
  assign pending_o = pend_q;

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == '0 && !zero_wr) |=> (cnt_q == $past(period_q))); // R5
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == W'(1) && !zero_wr) |=> pend_q); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(tick_i && cnt_q == W'(1) && !zero_wr)) |=> !pend_q); // R6
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0 && cnt_q == '0 && !pend_q) |=> !pend_q); // R7
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1536,
  parameter int unsigned SW_W     = 12,
  parameter int unsigned PER_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_we,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq_req
);
  localparam int unsigned SW_PAD  = BUS_W - SW_W;
  localparam int unsigned PER_PAD = BUS_W - PER_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick;
  logic             sw_clr, per_wr;
  logic [SW_W-1:0]  sw_count;
  logic [PER_W-1:0] period;
  logic             pending;
  logic             unused_wbits;
  reg_sel_e         sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    sel          = reg_sel_e'(reg_addr);
    sw_clr       = reg_we && (sel == SEL_STOPWATCH);
    per_wr       = reg_we && (sel == SEL_PERIOD);
    unused_wbits = ^reg_wdata[BUS_W-1:PER_W];
    case (sel)
      SEL_STOPWATCH: reg_rdata = {{SW_PAD{1'b0}}, sw_count};
      default:       reg_rdata = {{PER_PAD{1'b0}}, period};
    endcase
    irq_req = pending && irq_en;
  end

  tmr_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  tmr_stopwatch #(.W(SW_W)) u_sw (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (tick),
    .clr_i   (sw_clr),
    .count_o (sw_count)
  );

  tmr_interval #(.W(PER_W)) u_itmr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .wr_i      (per_wr),
    .wdata_i   (reg_wdata[PER_W-1:0]),
    .ack_i     (irq_ack),
    .period_o  (period),
    .pending_o (pending)
  );

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pending && irq_en && !irq_ack) |=> irq_req || !irq_en); // R8
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int DIV = 16;

  typedef struct packed {
    logic        wr;
    logic        ack;
    logic [15:0] data;
    logic [15:0] nticks;
    logic        irq;
    logic [7:0]  rd;
  } row_t;

  localparam row_t ROWS [12] = '{
    '{1'b1, 1'b0, 16'h0003, 16'd2, 1'b0, 8'h03},
    '{1'b0, 1'b0, 16'h0000, 16'd2, 1'b1, 8'h03},
    '{1'b0, 1'b0, 16'h0000, 16'd1, 1'b1, 8'h03},
    '{1'b0, 1'b1, 16'h0000, 16'd1, 1'b0, 8'h03},
    '{1'b0, 1'b0, 16'h0000, 16'd2, 1'b1, 8'h03},
    '{1'b1, 1'b1, 16'h0000, 16'd4, 1'b0, 8'h00},
    '{1'b1, 1'b0, 16'h0001, 16'd1, 1'b0, 8'h01},
    '{1'b0, 1'b0, 16'h0000, 16'd1, 1'b1, 8'h01},
    '{1'b1, 1'b1, 16'hFF05, 16'd1, 1'b0, 8'h05},
    '{1'b0, 1'b0, 16'h0000, 16'd4, 1'b0, 8'h05},
    '{1'b0, 1'b0, 16'h0000, 16'd1, 1'b1, 8'h05},
    '{1'b1, 1'b1, 16'h0000, 16'd2, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_addr, reg_we, irq_en, irq_ack, irq_req;
  logic [15:0] reg_wdata, reg_rdata;
  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  tick_timer #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // One register cycle at an aligned negedge, then n whole tick intervals.
  task automatic step(input logic we, input logic a, input logic [15:0] d,
                      input logic ack, input int n);
    reg_we = we; reg_addr = a; reg_wdata = d; irq_ack = ack;
    @(posedge clk); #1;
    reg_we = 1'b0; irq_ack = 1'b0;
    repeat (n * DIV - 1) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, prev;
    int cyc;
    rst_n = 1'b0; reg_addr = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    irq_en = 1'b1; irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(1'b0, v); chk("R9 stopwatch in reset", v, 16'h0000);
    rd(1'b1, v); chk("R9 period in reset", v, 16'h0000);
    chk("R9 irq in reset", {15'b0, irq_req}, 16'h0000);
    rst_n = 1'b1;

    // R1: lock onto the tick, then measure one interval
    rd(1'b0, prev);
    do begin @(negedge clk); rd(1'b0, v); end while (v == prev);
    chk("R1 first increment", v, 16'h0001);
    cyc = 0;
    do begin @(posedge clk); cyc++; @(negedge clk); rd(1'b0, v); end while (v == 16'h0001);
    chk("R1 tick spacing", 16'(cyc), 16'(DIV));
    chk("R2 stopwatch step", v, 16'h0002);

    // Table of period-register scenarios (R4 R5 R6 R7)
    for (int i = 0; i < 12; i++) begin
      step(ROWS[i].wr, 1'b1, ROWS[i].data, ROWS[i].ack, int'(ROWS[i].nticks));
      chk($sformatf("R6 row %0d irq", i), {15'b0, irq_req}, {15'b0, ROWS[i].irq});
      rd(1'b1, v);
      chk($sformatf("R4 row %0d period readback", i), v, {8'h00, ROWS[i].rd});
    end

    // R3: write of nonzero data clears the stopwatch; phase unchanged
    reg_addr = 1'b0; reg_we = 1'b1; reg_wdata = 16'hFABC;
    @(posedge clk); #1; reg_we = 1'b0;
    @(negedge clk); rd(1'b0, v); chk("R3 clear on write", v, 16'h0000);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk); rd(1'b0, v); chk("R3 count resumes after clear", v, 16'h0001);

    // R3: write landing on the tick edge still leaves zero
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    reg_addr = 1'b0; reg_we = 1'b1; reg_wdata = 16'h0123;
    @(posedge clk); #1; reg_we = 1'b0;
    @(negedge clk); rd(1'b0, v); chk("R3 write beats tick", v, 16'h0000);
    step(1'b0, 1'b0, 16'h0, 1'b0, 1);
    rd(1'b0, v); chk("R3 next tick after collision", v, 16'h0001);

    // R4: period write does not move the prescaler phase
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1);
    rd(1'b0, v); chk("R4 phase kept across period write", v, 16'h0002);

    // R8: mask gates request without clearing pending
    step(1'b1, 1'b1, 16'h0001, 1'b1, 2);
    chk("R8 pending visible", {15'b0, irq_req}, 16'h0001);
    irq_en = 1'b0; #1;
    chk("R8 masked", {15'b0, irq_req}, 16'h0000);
    step(1'b0, 1'b1, 16'h0, 1'b0, 1);
    chk("R8 masked after tick", {15'b0, irq_req}, 16'h0000);
    irq_en = 1'b1; #1;
    chk("R8 pending kept under mask", {15'b0, irq_req}, 16'h0001);

    // R6: acknowledge on the expiry edge loses to the expiry
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    irq_ack = 1'b1;
    @(posedge clk); #1; irq_ack = 1'b0;
    @(negedge clk);
    chk("R6 expiry beats ack", {15'b0, irq_req}, 16'h0001);
    step(1'b0, 1'b1, 16'h0, 1'b1, 1);
    chk("R6 ack clears", {15'b0, irq_req}, 16'h0000);

    // R7: zero period stops a running count and stays quiet
    step(1'b1, 1'b1, 16'h0000, 1'b1, 3);
    chk("R7 zero period quiet", {15'b0, irq_req}, 16'h0000);

    // R2: wrap from 0xFFF to 0
    step(1'b1, 1'b0, 16'h0000, 1'b0, 4095);
    rd(1'b0, v); chk("R2 full count", v, 16'h0FFF);
    step(1'b0, 1'b0, 16'h0, 1'b0, 1);
    rd(1'b0, v); chk("R2 wrap to zero", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule